// File: doc/BRIEF.md
# Open-Drain Bus Master with Stop-and-Restart Chaining

This core drives a two-wire serial bus (clock and data, both open-drain) as a master. Software supplies a byte and a one-cycle `go` strobe. The core then places a START condition, shifts the byte out most significant bit first, and samples the acknowledge slot on the ninth clock. After that it parks the clock low until the next command. The clock rate comes from a programmable divider. Each high phase starts only after the core has seen the released clock line reach the high level, so heavy bus loading and target clock stretching both lengthen the period.

Two features set this core apart. The first is arbitration handling. When the core loses arbitration it silently disables itself while the software enable still reads 1, and it re-arms itself once it sees a STOP condition on the bus. The second is the forced-stop request. It never cuts a byte short: it closes the transfer at the next byte boundary and, when start-chaining is selected, follows with a new START at once.

Top module: `i2cm_master`

## Requirements
- R1: After reset, both line enables are 0 (released), and `busy`, `byte_done`, `nack`, `arb_lost` and `ena` are all 0.
- R2: A transfer from idle places SDA low while SCL is high (START), then sends 8 data bits MSB first, each valid while SCL is high. It releases SDA for the ninth clock, holds SCL low afterwards and pulses `byte_done` once.
- R3: Measured from one SCL falling edge to the next, a bit takes 20 + 8·`div` + 3 + r cycles of `clk`. Here r is the number of cycles the bus keeps SCL low after the core releases it, and 3 is the synchronizer and decision latency.
- R4: While `men` is 0 the core never drives either line, and a `go` strobe starts nothing.
- R5: When the core releases SDA for a 1 during SCL high but reads SDA low, it releases both lines, sets `arb_lost` and drops `ena` while `men` stays 1. A later `go` starts nothing.
- R6: After an arbitration loss with `men` still 1, a STOP seen on the bus (SDA rising while SCL is high) raises `ena` again, and the next `go` runs a normal transfer.
- R7: The level of SDA sampled at the end of the ninth clock's high phase is reported on `nack` (1 = not acknowledged). With `nack` = 1 the core issues STOP by itself. With `nack` = 0 it keeps SCL low and waits.
- R8: A `fsb` strobe given in mid-byte lets the byte complete, with all nine clocks. The STOP (SDA rising while SCL is high) follows, and the core returns to idle.
- R9: If `esg` is 1 when a forced STOP completes, a new START follows directly, and the byte latched by the most recent `go` is sent.
- R10: A `go` while SCL is parked low after an acknowledged byte sends the next byte with no new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| men | input | 1 | Master enable |
| div | input | DIVW | Clock divider setting, must be stable before a transfer |
| go | input | 1 | One-cycle strobe: send `tx_data` |
| tx_data | input | 8 | Byte captured on `go` |
| fsb | input | 1 | One-cycle strobe: STOP at the next byte boundary |
| esg | input | 1 | Start-chaining select, sampled when a STOP completes |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Core is not idle |
| byte_done | output | 1 | One-cycle pulse after each byte's acknowledge slot |
| nack | output | 1 | Last acknowledge slot read high; cleared by `go` |
| arb_lost | output | 1 | Sticky arbitration-loss flag; cleared while `men` is 0 |
| ena | output | 1 | Master interface currently active |

## Verification
The assertions assume that `div` is held steady for the whole of a transfer. They also assume that `go` and `fsb` arrive as single-cycle strobes, and that bus lines move only through the wired-AND of the core and the bench agents. For that reason the bench changes `div` only while the core is idle. It drives every input one nanosecond after a rising edge. It models the rise delay as a release delay of the clock line and never adds glitches. The competing master in the arbitration test pulls SDA only while SCL is low, and it makes its STOP with SCL released.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_LOW, ST_RISE, ST_HIGH, ST_HOLD,
    ST_PLOW, ST_PRISE, ST_PHIGH, ST_PFREE
  } mst_state_e;
  localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st_q[s] <= '1;
        else        st_q[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st_q[s] <= '1;
        else        st_q[s] <= st_q[s-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic stop_det,
  output logic bus_busy
);
  logic scl_p, sda_p, busy_q, busy_d, start_det;

  assign start_det = scl_s & scl_p &  sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p &  sda_s;

  always_comb begin
    busy_d = busy_q;
    if (start_det)     busy_d = 1'b1;
    else if (stop_det) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_p  <= scl_s;
      sda_p  <= sda_s;
      busy_q <= busy_d;
    end

  assign bus_busy = busy_q;

  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !bus_busy); // R6
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int unsigned DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [DIVW-1:0] div,
  input  logic            go,
  input  logic [7:0]      tx_data,
  input  logic            fsb,
  input  logic            esg,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            bus_busy,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            busy,
  output logic            byte_done,
  output logic            nack,
  output logic            arb_hit
);
  localparam int unsigned CW     = DIVW + 4;
  localparam logic [3:0]  ACK_IX = 4'(BYTE_BITS);

  mst_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, ph_m1;
  logic [3:0]    bitn_q, bitn_d;
  logic [7:0]    sh_q, sh_d, txb_q, txb_d;
  logic          req_q, req_d, fsbp_q, fsbp_d, nack_q, nack_d;
  logic          done_q, done_d, sda_q, sda_d, tdone;

  // phase length 10 + 4*div; two phases plus the measured rise per bit
  assign ph_m1 = CW'(9) + (CW'(div) << 2);
  assign tdone = (cnt_q == ph_m1);

  always_comb begin
    state_d = state_q;
    bitn_d  = bitn_q;
    sh_d    = sh_q;
    txb_d   = txb_q;
    req_d   = req_q;
    fsbp_d  = fsbp_q;
    nack_d  = nack_q;
    done_d  = 1'b0;
    arb_hit = 1'b0;
    if (fsb && state_q != ST_IDLE) fsbp_d = 1'b1;
    unique case (state_q)
      ST_IDLE:  if (req_q && !bus_busy) begin
                  state_d = ST_START; sh_d = txb_q; bitn_d = '0; req_d = 1'b0;
                end
      ST_START: if (tdone) state_d = ST_LOW;
      ST_LOW:   if (tdone) state_d = ST_RISE;
      ST_RISE:  if (scl_s) state_d = ST_HIGH;
      ST_HIGH:
        if (bitn_q != ACK_IX && sh_q[7] && !sda_s) begin
          arb_hit = 1'b1; state_d = ST_IDLE; req_d = 1'b0; fsbp_d = 1'b0;
        end else if (tdone) begin
          if (bitn_q == ACK_IX) begin
            nack_d = sda_s; done_d = 1'b1; state_d = ST_HOLD;
          end else begin
            bitn_d = bitn_q + 4'd1; sh_d = {sh_q[6:0], 1'b0}; state_d = ST_LOW;
          end
        end
      ST_HOLD:
        if (fsbp_q || nack_q) state_d = ST_PLOW;
        else if (req_q) begin
          state_d = ST_LOW; sh_d = txb_q; bitn_d = '0; req_d = 1'b0;
        end
      ST_PLOW:  begin fsbp_d = 1'b0; if (tdone) state_d = ST_PRISE; end
      ST_PRISE: if (scl_s) state_d = ST_PHIGH;
      ST_PHIGH: if (tdone) state_d = ST_PFREE;
      ST_PFREE:
        if (tdone) begin
          req_d = 1'b0;
          if (esg) begin state_d = ST_START; sh_d = txb_q; bitn_d = '0; end
          else     state_d = ST_IDLE;
        end
      default:  state_d = ST_IDLE;
    endcase
    if (go && active) begin
      req_d = 1'b1; txb_d = tx_data; nack_d = 1'b0;
    end
    if (!active) begin
      state_d = ST_IDLE; req_d = 1'b0; fsbp_d = 1'b0; done_d = 1'b0;
    end
  end

  assign cnt_d = (state_d != state_q) ? '0 : cnt_q + CW'(1);

  // data line moves one cycle after the clock line falls
  always_comb begin
    unique case (state_q)
      ST_START, ST_PLOW, ST_PRISE, ST_PHIGH: sda_d = 1'b1;
      ST_LOW, ST_RISE, ST_HIGH:              sda_d = (bitn_q != ACK_IX) & ~sh_q[7];
      default:                               sda_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      txb_q   <= '0;
      req_q   <= 1'b0;
      fsbp_q  <= 1'b0;
      nack_q  <= 1'b0;
      done_q  <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bitn_q  <= bitn_d;
      sh_q    <= sh_d;
      txb_q   <= txb_d;
      req_q   <= req_d;
      fsbp_q  <= fsbp_d;
      nack_q  <= nack_d;
      done_q  <= done_d;
      sda_q   <= sda_d;
    end

  assign scl_oe    = (state_q == ST_LOW) || (state_q == ST_HOLD) || (state_q == ST_PLOW);
  assign sda_oe    = sda_q;
  assign busy      = (state_q != ST_IDLE);
  assign byte_done = done_q;
  assign nack      = nack_q;

  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_hit |=> (!scl_oe && state_q == ST_IDLE)); // R5
  AST_DONE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (state_q == ST_HOLD && scl_oe)); // R2
  AST_STOP_AT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PLOW && $past(state_q) != ST_PLOW) |-> $past(state_q) == ST_HOLD); // R8
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && nack_q && active) |=> state_q == ST_PLOW); // R7
  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && $past(state_q) != ST_START)
      |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_PFREE)); // R9
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master #(
  parameter int unsigned DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            men,
  input  logic [DIVW-1:0] div,
  input  logic            go,
  input  logic [7:0]      tx_data,
  input  logic            fsb,
  input  logic            esg,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            busy,
  output logic            byte_done,
  output logic            nack,
  output logic            arb_lost,
  output logic            ena
);
  logic [1:0] rs_q;
  logic       rst_i, scl_s, sda_s, stop_det, bus_busy, arb_hit;
  logic       dis_q, dis_d, arb_q, arb_d;
  logic [1:0] lines_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_i = rs_q[1];

  i2cm_sync #(.N(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_i), .d({scl_i, sda_i}), .q(lines_s));
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cm_busmon u_mon (
    .clk(clk), .rst_n(rst_i), .scl_s(scl_s), .sda_s(sda_s),
    .stop_det(stop_det), .bus_busy(bus_busy));

  assign ena = men & ~dis_q;

  i2cm_ctrl #(.DIVW(DIVW)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .active(ena), .div(div), .go(go),
    .tx_data(tx_data), .fsb(fsb), .esg(esg), .scl_s(scl_s), .sda_s(sda_s),
    .bus_busy(bus_busy), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .byte_done(byte_done), .nack(nack), .arb_hit(arb_hit));

  always_comb begin
    dis_d = dis_q;
    arb_d = arb_q;
    if (arb_hit)                 dis_d = 1'b1;
    else if (stop_det || !men)   dis_d = 1'b0;
    if (arb_hit)                 arb_d = 1'b1;
    else if (!men)               arb_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i) begin
      dis_q <= 1'b0;
      arb_q <= 1'b0;
    end else begin
      dis_q <= dis_d;
      arb_q <= arb_d;
    end

  assign arb_lost = arb_q;

  AST_MEN_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    (!men && $past(!men) && $past(!men, 2)) |-> (!scl_oe && !sda_oe)); // R4
  AST_DIS_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    dis_q |-> !busy); // R5
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_i)
    (dis_q && stop_det && men) |=> ena); // R6
endmodule

// File: tb/test_i2cm_master.sv
module test_i2cm_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       men = 1'b0, go = 1'b0, fsb = 1'b0, esg = 1'b0;
  logic [7:0] div = 8'd0, tx_data = 8'd0;
  logic       scl_oe, sda_oe, busy, byte_done, nack, arb_lost, ena;
  logic [7:0] hist = '0, dmask = '0;
  logic       oth_sda = 1'b0, ack_en = 1'b0, slv_ack = 1'b0, chk_off = 1'b0;
  logic       scl_b, sda_b, scl_pv = 1'b1, sda_pv = 1'b1;
  logic [7:0] rxs = '0, last_byte = '0;
  int tests = 0, fails = 0, tcnt = 0, starts = 0, stops = 0, falls = 0;
  int t1 = 0, t2 = 0, nbytes = 0, stop_falls = 0, off_drive = 0;

  // div[29:22] rise[21:18] byte[17:10] ack[9] period[8:1] nack[0]
  localparam logic [29:0] VEC [5] = '{
    {8'd0, 4'd0, 8'hA5, 1'b1, 8'd23, 1'b0},
    {8'd2, 4'd0, 8'h3C, 1'b1, 8'd39, 1'b0},
    {8'd1, 4'd3, 8'hFF, 1'b1, 8'd34, 1'b0},
    {8'd3, 4'd5, 8'h00, 1'b0, 8'd52, 1'b1},
    {8'd0, 4'd7, 8'h81, 1'b1, 8'd30, 1'b0}
  };

  always #2 clk = ~clk;

  assign scl_b = ~(scl_oe | (|(hist & dmask)));
  assign sda_b = ~(sda_oe | slv_ack | oth_sda);

  always @(posedge clk) hist <= {hist[6:0], scl_oe};

  i2cm_master i_i2cm_master (
    .clk(clk), .rst_n(rst_n), .men(men), .div(div), .go(go), .tx_data(tx_data),
    .fsb(fsb), .esg(esg), .scl_i(scl_b), .sda_i(sda_b), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .busy(busy), .byte_done(byte_done), .nack(nack),
    .arb_lost(arb_lost), .ena(ena));

  always @(negedge clk) begin
    tcnt++;
    if (rst_n) begin
      if (scl_pv && scl_b && sda_pv && !sda_b) begin starts++; falls = 0; end
      else if (scl_pv && scl_b && !sda_pv && sda_b) begin stops++; stop_falls = falls; end
      if (scl_pv && !scl_b) begin
        falls++;
        if (falls == 1) t1 = tcnt;
        if (falls == 2) t2 = tcnt;
      end
      if (!scl_pv && scl_b && (falls % 9) != 0) begin
        rxs = {rxs[6:0], sda_b};
        if ((falls % 9) == 8) begin last_byte = rxs; nbytes++; end
      end
      slv_ack = ack_en && falls != 0 && (falls % 9) == 0;
      if (chk_off && (scl_oe || sda_oe)) off_drive++;
    end
    scl_pv = scl_b;
    sda_pv = sda_b;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_go(input logic [7:0] b);
    tx_data = b; go = 1'b1; tick(1); go = 1'b0;
  endtask

  task automatic pulse_fsb();
    fsb = 1'b1; tick(1); fsb = 1'b0;
  endtask

  task automatic wait_done();
    tick(1);
    while (!byte_done) tick(1);
  endtask

  task automatic wait_idle();
    tick(1);
    while (busy) tick(1);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", tcnt, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s0, p0, n0;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines", {30'd0, scl_oe, sda_oe}, 0);
    chk(!busy && !byte_done, "R1 busy", {30'd0, busy, byte_done}, 0);
    chk(!nack && !arb_lost && !ena, "R1 flags", {29'd0, nack, arb_lost, ena}, 0);

    // R4 disabled master stays off the bus
    chk_off = 1'b1; s0 = starts;
    pulse_go(8'h55);
    tick(200);
    chk(off_drive == 0, "R4 drive", off_drive, 0);
    chk(!busy && starts == s0, "R4 go ignored", starts - s0, 0);
    chk_off = 1'b0;
    men = 1'b1; tick(4);
    chk(ena && !busy, "R4 enable", {30'd0, ena, busy}, 2);

    // vector walk: R2 byte, R3 period, R7 acknowledge
    foreach (VEC[k]) begin
      div = VEC[k][29:22];
      dmask = 8'((1 << VEC[k][21:18]) - 1);
      ack_en = VEC[k][9];
      s0 = starts; p0 = stops;
      tick(2);
      pulse_go(VEC[k][17:10]);
      wait_done();
      chk(last_byte == VEC[k][17:10], "R2 byte", last_byte, VEC[k][17:10]);
      chk(starts == s0 + 1, "R2 start", starts - s0, 1);
      chk(t2 - t1 == int'(VEC[k][8:1]), "R3 period", t2 - t1, VEC[k][8:1]);
      chk(nack == VEC[k][0], "R7 nack", nack, VEC[k][0]);
      if (VEC[k][9]) begin
        tick(20);
        chk(scl_oe && busy && stops == p0, "R7 parked", stops - p0, 0);
        pulse_fsb();
      end
      wait_idle();
      chk(stops == p0 + 1 && stop_falls == 10, "R7 R8 stop", stop_falls, 10);
    end
    dmask = '0; ack_en = 1'b1; div = 8'd1;

    // R10 second byte without a new START
    s0 = starts; n0 = nbytes;
    pulse_go(8'hC3);
    wait_done();
    pulse_go(8'h69);
    wait_done();
    chk(last_byte == 8'h69 && nbytes == n0 + 2, "R10 byte", last_byte, 8'h69);
    chk(starts == s0 + 1, "R10 no restart", starts - s0, 1);
    pulse_fsb();
    wait_idle();

    // R8 forced stop requested early waits for the whole byte
    p0 = stops; n0 = nbytes;
    pulse_go(8'h96);
    tick(3);
    pulse_fsb();
    wait_idle();
    chk(nbytes == n0 + 1 && last_byte == 8'h96, "R8 byte", last_byte, 8'h96);
    chk(stops == p0 + 1 && stop_falls == 10, "R8 nine clocks", stop_falls, 10);

    // R9 forced stop chained into a new START
    esg = 1'b1; s0 = starts; p0 = stops;
    pulse_go(8'h4E);
    tick(4);
    pulse_fsb();
    pulse_go(8'hB1);
    wait_done();
    wait_done();
    esg = 1'b0;
    chk(last_byte == 8'hB1, "R9 byte", last_byte, 8'hB1);
    chk(starts == s0 + 2 && stops == p0 + 1, "R9 restart", starts - s0, 2);
    pulse_fsb();
    wait_idle();

    // R5 arbitration loss
    ack_en = 1'b0; s0 = starts;
    pulse_go(8'hFF);
    while (starts == s0 || falls < 1) tick(1);
    oth_sda = 1'b1;
    while (!arb_lost) tick(1);
    tick(3);
    chk(!scl_oe && !sda_oe, "R5 release", {30'd0, scl_oe, sda_oe}, 0);
    chk(men && !ena && !busy, "R5 disabled", {30'd0, ena, busy}, 0);
    pulse_go(8'h12);
    tick(100);
    chk(!busy && !scl_oe && !sda_oe, "R5 go ignored", {31'd0, busy}, 0);

    // R6 STOP from the other master re-arms
    oth_sda = 1'b0;
    tick(6);
    chk(ena && arb_lost, "R6 rearm", {30'd0, ena, arb_lost}, 3);
    ack_en = 1'b1; s0 = starts;
    pulse_go(8'h5A);
    wait_done();
    chk(last_byte == 8'h5A && starts == s0 + 1, "R6 transfer", last_byte, 8'h5A);
    pulse_fsb();
    wait_idle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule